// File: doc/BRIEF.md
# Register File Byte-Field Scanner

This block searches a byte-addressed register file of 32 words of 32 bits for a 1-, 2- or 4-byte value. A single 32-bit control word supplies the first byte offset, how many fields to examine, the field size and the byte distance between consecutive fields. Because size and distance are independent, a multi-byte value can be found at any byte alignment, for example a 2-byte value searched one byte at a time.

The engine examines one field per clock through a combinational read port that returns a pair of adjacent words. When the search ends it pulses done and presents a result word in the same packing as the control word: the low byte holds the offset of the hit (or 0xFF), the next byte holds the number of fields still unexamined including the hit, and the upper two bytes come back untouched. Adding 0xFF01 to the low 16 bits of that result and starting again resumes the search one byte past the hit.

Top module: `rf_field_scanner`

## Requirements
- R1: A start pulse while idle loads the control word and the pattern, and busy is high from the next cycle until done is pulsed; control byte 0 is the start byte offset, byte 1 the field count, byte 2 the field size, byte 3 the stride.
- R2: Field size value 1 compares one byte, value 2 compares two bytes, any other value compares four bytes; pattern bits above the field size are ignored.
- R3: Byte offset b names bits 8*(b mod 4)+7 down to 8*(b mod 4) of word b/4, and a multi-byte field is compared little-endian, the byte at the lowest offset against pattern bits 7:0.
- R4: One field is tested per clock: a hit on field index i (counting from 0) raises done i+1 cycles after the start edge, and each miss advances the offset by the stride byte and lowers the count by one.
- R5: On a hit, result bits 7:0 hold the byte offset of the matching field and bits 15:8 the number of fields not yet examined counting the hit.
- R6: When every field misses, result bits 7:0 are 0xFF and bits 15:8 are 0, with done raised count+1 cycles after the start edge.
- R7: A field count of zero ends the scan one cycle after the start edge with 0xFF and 0.
- R8: A field whose last byte would lie beyond byte 127 is a miss, even when the wrapped read data would equal the pattern.
- R9: Result bits 31:16 equal control bits 31:16 of the scan that produced it.
- R10: Done is high for exactly one cycle per scan, and the result stays unchanged between done pulses.
- R11: A start pulse while busy has no effect on the running scan or its result.
- R12: Adding 0xFF01 to the low 16 bits of a hit result and starting with it finds the next hit after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a scan when idle |
| ctrl_i | input | 32 | Control word: offset, count, size, stride |
| pattern_i | input | 32 | Value searched for, little-endian |
| rf_addr_o | output | 5 | Word index of the lower word of the read pair |
| rf_data_i | input | 64 | {word[addr+1 mod 32], word[addr]} from the register file |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| result_o | output | 32 | Result word, held until the next done |

## Verification
The hardest case to reach is a field at the top of the register file whose wrapped read pair happens to equal the pattern, since random contents almost never line up across the wrap. The bench plants a 4-byte value split between the last word and the first word and scans from offset 126, where a design without the range check would report a hit. Resumed searches are made reachable by filling the file with a small alphabet of byte values so hits recur, then feeding each result back with 0xFF01 added.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    typedef struct packed {
        scan_state_e state;
        logic [15:0] off;
        logic [7:0]  cnt;
        logic [2:0]  width;
        logic [7:0]  stride;
        logic [15:0] upper;
        logic [31:0] pat;
        logic        done;
        logic [31:0] result;
    } scan_regs_s;

    function automatic logic [2:0] size_decode(input logic [7:0] code);
        logic [2:0] w;
        case (code)
            8'd1:    w = 3'd1;
            8'd2:    w = 3'd2;
            default: w = 3'd4;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/rfs_field_cmp.sv
module rfs_field_cmp #(
    parameter int RF_BYTES = 128,
    parameter int OFF_W    = 16
) (
    input  logic [OFF_W-1:0] off_i,
    input  logic [2:0]       width_i,
    input  logic [31:0]      pat_i,
    input  logic [63:0]      pair_i,
    output logic             hit_o
);
    localparam int SUM_W = OFF_W + 1;

    logic [63:0]      shifted;
    logic [31:0]      mask;
    logic [SUM_W-1:0] end_pos;
    logic             in_range;

    always_comb begin
        shifted  = pair_i >> {off_i[1:0], 3'b000};
        case (width_i)
            3'd1:    mask = 32'h0000_00FF;
            3'd2:    mask = 32'h0000_FFFF;
            default: mask = 32'hFFFF_FFFF;
        endcase
        end_pos  = SUM_W'(off_i) + SUM_W'(width_i);
        in_range = end_pos <= SUM_W'(RF_BYTES);
        hit_o    = in_range && (((shifted[31:0] ^ pat_i) & mask) == 32'd0);
    end

endmodule

// File: rtl/rfs_advance.sv
module rfs_advance #(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W-1:0] off_i,
    input  logic [7:0]       stride_i,
    input  logic [7:0]       cnt_i,
    output logic [OFF_W-1:0] off_o,
    output logic [7:0]       cnt_o
);
    logic [OFF_W:0] sum;

    always_comb begin
        sum   = {1'b0, off_i} + (OFF_W+1)'(stride_i);
        off_o = sum[OFF_W] ? {OFF_W{1'b1}} : sum[OFF_W-1:0];
        cnt_o = (cnt_i == 8'd0) ? 8'd0 : cnt_i - 8'd1;
    end

endmodule

// File: rtl/rf_field_scanner.sv
module rf_field_scanner #(
    parameter int RF_WORDS = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [31:0]                 ctrl_i,
    input  logic [31:0]                 pattern_i,
    output logic [$clog2(RF_WORDS)-1:0] rf_addr_o,
    input  logic [63:0]                 rf_data_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic [31:0]                 result_o
);
    import rfs_pkg::*;

    localparam int ADDR_W   = $clog2(RF_WORDS);
    localparam int RF_BYTES = RF_WORDS * 4;
    localparam int OFF_W    = 16;

    scan_regs_s r_d, r_q;

    logic             hit;
    logic [OFF_W-1:0] off_nx;
    logic [7:0]       cnt_nx;

    rfs_field_cmp #(
        .RF_BYTES (RF_BYTES),
        .OFF_W    (OFF_W)
    ) u_cmp (
        .off_i   (r_q.off),
        .width_i (r_q.width),
        .pat_i   (r_q.pat),
        .pair_i  (rf_data_i),
        .hit_o   (hit)
    );

    rfs_advance #(
        .OFF_W (OFF_W)
    ) u_adv (
        .off_i    (r_q.off),
        .stride_i (r_q.stride),
        .cnt_i    (r_q.cnt),
        .off_o    (off_nx),
        .cnt_o    (cnt_nx)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state  = ST_SCAN;
                    r_d.off    = OFF_W'(ctrl_i[7:0]);
                    r_d.cnt    = ctrl_i[15:8];
                    r_d.width  = size_decode(ctrl_i[23:16]);
                    r_d.stride = ctrl_i[31:24];
                    r_d.upper  = ctrl_i[31:16];
                    r_d.pat    = pattern_i;
                end
            end
            default: begin
                if (r_q.cnt == 8'd0) begin
                    r_d.state  = ST_IDLE;
                    r_d.done   = 1'b1;
                    r_d.result = {r_q.upper, 8'h00, 8'hFF};
                end else if (hit) begin
                    r_d.state  = ST_IDLE;
                    r_d.done   = 1'b1;
                    r_d.result = {r_q.upper, r_q.cnt, r_q.off[7:0]};
                end else begin
                    r_d.off = off_nx;
                    r_d.cnt = cnt_nx;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rf_addr_o = r_q.off[ADDR_W+1:2];
    assign busy_o    = (r_q.state == ST_SCAN);
    assign done_o    = r_q.done;
    assign result_o  = r_q.result;

endmodule

// File: rtl/rfs_checker.sv
module rfs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [31:0] ctrl_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [31:0] result_o
);
    logic [15:0] upper_q;
    logic [7:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            cnt_q   <= '0;
        end else if (start_i && !busy_o) begin
            upper_q <= ctrl_i[31:16];
            cnt_q   <= ctrl_i[15:8];
        end
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !done_o) |=> busy_o) else $error("start"); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("pulse"); // R10
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o)) else $error("held"); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o) else $error("idle"); // R1
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o[7:0] == 8'hFF) |-> (result_o[15:8] == 8'd0)) else $error("miss"); // R6
    AST_HIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o[7:0] != 8'hFF) |->
        (result_o[15:8] != 8'd0 && result_o[15:8] <= cnt_q)) else $error("hitcnt"); // R5
    AST_HIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o[7:0] != 8'hFF) |-> (result_o[7:0] < 8'd128)) else $error("range"); // R8
    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o[31:16] == upper_q)) else $error("upper"); // R9

endmodule

bind rf_field_scanner rfs_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .ctrl_i   (ctrl_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/rf_field_scanner_tb.sv
module rf_field_scanner_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] ctrl_i = '0;
    logic [31:0] pattern_i = '0;
    logic [4:0]  rf_addr_o;
    logic [63:0] rf_data_i;
    logic        busy_o, done_o;
    logic [31:0] result_o;

    logic [31:0] rf [32];
    logic [4:0]  addr_nx;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    assign addr_nx   = rf_addr_o + 5'd1;
    assign rf_data_i = {rf[addr_nx], rf[rf_addr_o]};

    rf_field_scanner u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .ctrl_i    (ctrl_i),
        .pattern_i (pattern_i),
        .rf_addr_o (rf_addr_o),
        .rf_data_i (rf_data_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .result_o  (result_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rf_byte(input int b);
        if (b < 0 || b > 127) return 8'h00;
        return rf[b / 4][(b % 4) * 8 +: 8];
    endfunction

    function automatic void ref_scan(input logic [31:0] c, input logic [31:0] p,
                                     output logic [31:0] res, output int cyc);
        int off, cnt, w, st;
        bit hit;
        off = c[7:0];
        cnt = c[15:8];
        w   = (c[23:16] == 8'd1) ? 1 : (c[23:16] == 8'd2) ? 2 : 4;
        st  = c[31:24];
        cyc = 1;
        while (cnt != 0) begin
            hit = (off + w <= 128);
            for (int k = 0; k < w; k++)
                if (hit && rf_byte(off + k) != p[k*8 +: 8]) hit = 0;
            if (hit) begin
                res = {c[31:16], 8'(cnt), 8'(off)};
                return;
            end
            off += st;
            cnt--;
            cyc++;
        end
        res = {c[31:16], 16'h00FF};
    endfunction

    function automatic logic [31:0] pick_pat(input int b);
        return {rf_byte(b + 3), rf_byte(b + 2), rf_byte(b + 1), rf_byte(b)};
    endfunction

    task automatic pulse_start(input logic [31:0] c, input logic [31:0] p);
        @(negedge clk);
        start_i   = 1'b1;
        ctrl_i    = c;
        pattern_i = p;
        @(negedge clk);
        start_i   = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!done_o) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", n);
        end
    endtask

    task automatic run_scan(input logic [31:0] c, input logic [31:0] p, input string req,
                            output logic [31:0] got);
        logic [31:0] exp;
        int cyc, n;
        ref_scan(c, p, exp, cyc);
        pulse_start(c, p);
        wait_done(n);
        got = result_o;
        check(result_o == exp, {req, " result (R5 R6 R9)"}, result_o, exp);
        check(n == cyc, {req, " latency R4"}, n, cyc);
        @(negedge clk);
        check(!done_o, "R10 done one cycle", {31'd0, done_o}, 32'd0);
        check(result_o == got, "R10 result held", result_o, got);
    endtask

    initial begin
        logic [31:0] r, c;
        int n;
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) rf[i] = $urandom;

        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && result_o == 32'd0, "R1 reset state",
              {busy_o, done_o, result_o[29:0]}, 32'd0);
        rst_n = 1'b1;

        // R1 R3: aligned byte hit in word 2, byte 1
        rf[2] = 32'h4433_2211;
        pulse_start({8'd1, 8'd1, 8'd20, 8'd4}, 32'h0000_0022);
        @(negedge clk);
        check(busy_o, "R1 busy after start", {31'd0, busy_o}, 32'd1);
        wait_done(n);
        check(result_o == {8'd1, 8'd1, 8'd15, 8'd9}, "R3 byte position", result_o, {8'd1, 8'd1, 8'd15, 8'd9});
        @(negedge clk);

        // R3: little-endian 2-byte field crossing a word boundary
        rf[3] = 32'h0000_00AB;
        rf[2] = 32'hCD00_0000;
        run_scan({8'd1, 8'd2, 8'd10, 8'd8}, 32'h0000_ABCD, "R3 cross word", r);
        check(r[7:0] == 8'd11, "R3 offset of split field", r, 32'd11);

        // R2: upper pattern bits ignored for width 1 and 2
        run_scan({8'd1, 8'd1, 8'd10, 8'd8}, 32'hFFFF_FFCD, "R2 width1 mask", r);
        run_scan({8'd1, 8'd2, 8'd10, 8'd11}, 32'h5555_00AB, "R2 width2 mask", r);
        run_scan({8'd1, 8'd3, 8'd10, 8'd11}, 32'h5555_00AB, "R2 width code 3 as 4", r);

        // R7: zero count
        run_scan({8'd1, 8'd1, 8'd0, 8'd0}, 32'h0, "R7 zero count", r);
        check(r[15:0] == 16'h00FF, "R7 zero count result", r, {16'h0101, 16'h00FF});

        // R8: wrapped read would match at offset 126
        rf[31] = 32'hBEEF_0000;
        rf[0]  = 32'h1234_5678;
        run_scan({8'd1, 8'd4, 8'd1, 8'd126}, 32'h5678_BEEF, "R8 end of file", r);
        check(r[7:0] == 8'hFF, "R8 no wrap hit", r, 32'hFF);

        // R6: guaranteed miss
        for (int i = 0; i < 32; i++) rf[i] = 32'h0101_0101;
        run_scan({8'd4, 8'd1, 8'd30, 8'd0}, 32'h0000_0077, "R6 no hit", r);

        // R11: start ignored while busy
        begin
            logic [31:0] exp;
            int cyc;
            ref_scan({8'd1, 8'd1, 8'd50, 8'd0}, 32'h77, exp, cyc);
            pulse_start({8'd1, 8'd1, 8'd50, 8'd0}, 32'h77);
            repeat (5) @(negedge clk);
            rf[3] = 32'h0101_0177;
            start_i = 1'b1; ctrl_i = {8'd2, 8'd2, 8'd9, 8'd0}; pattern_i = 32'h0101;
            @(negedge clk);
            start_i = 1'b0;
            rf[3] = 32'h0101_0101;
            wait_done(n);
            check(result_o == exp, "R11 start while busy", result_o, exp);
            check(n == cyc - 6, "R11 latency unchanged", n, cyc - 6);
            @(negedge clk);
        end

        // R12: resume search with repeating contents
        for (int i = 0; i < 32; i++) rf[i] = (i % 3 == 0) ? 32'h00A5_5A00 : 32'h0;
        c = {8'd1, 8'd2, 8'd100, 8'd0};
        for (int k = 0; k < 4; k++) begin
            logic [31:0] prev;
            run_scan(c, 32'h0000_A55A, "R12 resume", r);
            if (k > 0) check(r[7:0] > prev[7:0] || r[7:0] == 8'hFF, "R12 next hit later", r, prev);
            prev = r;
            c = {r[31:16], r[15:0] + 16'hFF01};
        end

        // random scans over a small byte alphabet
        for (int t = 0; t < 250; t++) begin
            logic [7:0] codes [4];
            codes = '{8'd1, 8'd2, 8'd4, 8'd3};
            for (int i = 0; i < 32; i++)
                rf[i] = {6'd0, 2'($urandom), 6'd0, 2'($urandom), 6'd0, 2'($urandom), 6'd0, 2'($urandom)};
            c = {8'(1 + $urandom % 4), codes[$urandom % 4], 8'($urandom % 48), 8'($urandom % 130)};
            run_scan(c, ($urandom % 4 == 0) ? $urandom : pick_pat($urandom % 128),
                     "R4 random", r);
            if (r[7:0] != 8'hFF && t % 2 == 0)
                run_scan({r[31:16], r[15:0] + 16'hFF01}, pattern_i, "R12 random resume", r);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule